// File: doc/BRIEF.md
# Bloom Array Rebuild Scheduler

This block sits beside a per-set hit/miss predictor built from small counting Bloom arrays, one per cache set. When the predictor tries to decrement a saturated counter and cannot, because that array has seen an overflow, it reports a failed decrement for the set. After a set has collected enough of these failures, its array no longer matches the tags it should represent. The scheduler records that the set is stale and puts its index into a small ordered queue. Later it asks an external engine to rebuild that array from the tags.

Rebuilds are rate-limited by cache traffic. Every time a configured number of cache accesses have been seen, the scheduler takes the oldest queued set and raises a rebuild request carrying its index. The request stays high until the rebuild engine answers with a done pulse. If the queue has no room when a set becomes stale, the set is marked pending instead. The next access to that set tries the enqueue again. A single enable input switches the whole mechanism off.

Top module: `bloom_rebuild_sched`

## Requirements
- R1: After reset the rebuild request is low, the queue is empty, and every set's failure count, queued bit and pending bit are zero.
- R2: While enabled, a set is enqueued in the cycle in which its FAIL_LIMIT-th failed decrement arrives. Fewer failures cause no rebuild.
- R3: Enabled accesses to any set advance a period counter. Every PERIOD-th enabled access is an issue opportunity. If the queue is non-empty and no request is outstanding, the head is popped and rb_req rises in the next cycle. An opportunity that meets an empty queue or a busy request is lost.
- R4: Queued sets are issued in the order they were enqueued, and rb_set carries the set index of the request.
- R5: rb_req and rb_set hold steady until rb_done is sampled high, and rb_req is low in the following cycle. Only one request is outstanding at a time.
- R6: If a set reaches its limit while the queue is full, it becomes pending. The next enabled access to that set retries the enqueue, and a successful retry clears the pending bit. A pending set is never also queued.
- R7: Issuing a set clears its failure count and its queued bit, so FAIL_LIMIT fresh failures are needed to queue it again. Extra failures on a set that is already queued add no second entry.
- R8: While enable is low, failure events are ignored (counts do not advance), accesses neither advance the period counter nor retry pending sets, and no new request is raised.
- R9: When the queue is full and a pop happens in the same cycle as an enqueue, the enqueue is accepted and the set does not become pending.
- R10: At most one enqueue happens per cycle. A threshold crossing from a failure wins over a pending retry from an access in the same cycle, and the losing set stays pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Turns the whole rebuild mechanism on |
| fail_valid | input | 1 | A decrement failed because of overflow this cycle |
| fail_set | input | SET_W | Set index of the failed decrement |
| acc_valid | input | 1 | A cache access occurs this cycle |
| acc_set | input | SET_W | Set index of the cache access |
| rb_done | input | 1 | Rebuild engine finished the outstanding request |
| rb_req | output | 1 | Rebuild request, held until done |
| rb_set | output | SET_W | Set whose array must be rebuilt |

## Verification
The hardest situations to reach are the collisions on a full queue. One is a threshold crossing in the same cycle as a pop. Another is a threshold crossing that competes with a pending retry. Both need the queue filled first, a pending set created, and the period counter brought to exactly one access short of its tick, so that a chosen access completes the period. The bench resets before each scenario so that the phase of the period is known. It then combines a failure on one set and an access on another in a single cycle. Which set was accepted is proven later, by draining the queue through further request and done cycles.

// File: rtl/brs_pkg.sv
// Shared helpers for the Bloom array rebuild scheduler.
// Assumes: callers pass positive sizes.
package brs_pkg;
    // Width needed to index n items, never less than one bit.
    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/brs_period_timer.sv
// Period timer: pulses tick on every PERIOD-th step.
// Assumes: PERIOD >= 1; step is already qualified by enable.
module brs_period_timer #(
    parameter int PERIOD = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    output logic tick
);
    import brs_pkg::*;
    localparam int CW = idx_w(PERIOD);
    localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

    logic [CW-1:0] cnt_q;

    // Issue opportunity when the step completes a period.
    assign tick = step && (cnt_q == LAST);

    // Count qualified steps, wrapping after the last one of a period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/brs_fifo.sv
// Ordered queue of set indices awaiting rebuild.
// Assumes: pop only when not empty; push only when not full or popping.
module brs_fifo #(
    parameter int DEPTH = 4,
    parameter int DW    = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push,
    input  logic [DW-1:0]                 push_data,
    input  logic                          pop,
    output logic [DW-1:0]                 head,
    output logic                          full,
    output logic                          empty,
    output logic [brs_pkg::idx_w(DEPTH+1)-1:0] count
);
    import brs_pkg::*;
    localparam int PW = idx_w(DEPTH);
    localparam int CW = idx_w(DEPTH + 1);
    localparam logic [PW-1:0] PLAST = PW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    // Status and head view.
    assign head  = mem[rd_q];
    assign full  = (cnt_q == CW'(DEPTH));
    assign empty = (cnt_q == '0);
    assign count = cnt_q;

    // Storage write on push.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_q] <= push_data;
        end
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PLAST) ? '0 : wr_q + PW'(1);
            if (pop)  rd_q <= (rd_q == PLAST) ? '0 : rd_q + PW'(1);
            case ({push, pop})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end
endmodule

// File: rtl/brs_set_tracker.sv
// Per-set staleness state: saturating failure count, queued bit, pending bit.
// Assumes: hit inputs are already qualified by enable and set decode;
// grant is high only in a cycle where this set asked (trig or retry).
module brs_set_tracker #(
    parameter int FAIL_LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fail_hit,
    input  logic acc_hit,
    input  logic issue_hit,
    input  logic grant,
    output logic trig,
    output logic retry,
    output logic in_q,
    output logic pend
);
    import brs_pkg::*;
    localparam int CW = idx_w(FAIL_LIMIT + 1);
    localparam logic [CW-1:0] LIM  = CW'(FAIL_LIMIT);
    localparam logic [CW-1:0] PREV = CW'(FAIL_LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic          inq_q, pend_q;

    assign in_q = inq_q;
    assign pend = pend_q;

    // Threshold crossing and retry requests toward the arbiter.
    assign trig  = fail_hit && !issue_hit && !inq_q && !pend_q && (cnt_q == PREV);
    assign retry = acc_hit && pend_q && !issue_hit;

    // State update; an issue of this set clears everything first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            inq_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (issue_hit) begin
            cnt_q  <= '0;
            inq_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (fail_hit && cnt_q != LIM) cnt_q <= cnt_q + CW'(1);
            if (grant) begin
                inq_q  <= 1'b1;
                pend_q <= 1'b0;
            end else if (trig) begin
                pend_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/bloom_rebuild_sched.sv
// Top of the rebuild scheduler: per-set trackers, enqueue arbiter,
// ordered queue, period timer and the held request toward the rebuild engine.
// Assumes: fail_set/acc_set beyond NUM_SETS-1 match no tracker.
module bloom_rebuild_sched #(
    parameter int NUM_SETS    = 16,
    parameter int FAIL_LIMIT  = 4,
    parameter int PERIOD      = 1,
    parameter int QUEUE_DEPTH = 4,
    parameter int SET_W       = brs_pkg::idx_w(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fail_valid,
    input  logic [SET_W-1:0] fail_set,
    input  logic             acc_valid,
    input  logic [SET_W-1:0] acc_set,
    input  logic             rb_done,
    output logic             rb_req,
    output logic [SET_W-1:0] rb_set
);
    import brs_pkg::*;
    localparam int QCW = idx_w(QUEUE_DEPTH + 1);

    logic                fail_en, acc_en, tick, issue;
    logic                q_full, q_empty, enq;
    logic [SET_W-1:0]    q_head, cand_set;
    logic [QCW-1:0]      q_count;
    logic                cand_valid, fail_trig_any;
    logic [NUM_SETS-1:0] trig_v, retry_v, inq_v, pend_v;
    logic                req_q;
    logic [SET_W-1:0]    set_q;

    // Qualify events by enable.
    assign fail_en = enable && fail_valid;
    assign acc_en  = enable && acc_valid;

    brs_period_timer #(.PERIOD(PERIOD)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (acc_en),
        .tick  (tick)
    );

    // Pop the head when a period completes, work waits and nothing is outstanding.
    assign issue = tick && !q_empty && !req_q;

    // One enqueue per cycle; a failure crossing beats a pending retry.
    assign fail_trig_any = |trig_v;
    assign cand_valid    = fail_trig_any || (|retry_v);
    assign cand_set      = fail_trig_any ? fail_set : acc_set;
    assign enq           = cand_valid && (!q_full || issue);

    brs_fifo #(.DEPTH(QUEUE_DEPTH), .DW(SET_W)) u_queue (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (enq),
        .push_data (cand_set),
        .pop       (issue),
        .head      (q_head),
        .full      (q_full),
        .empty     (q_empty),
        .count     (q_count)
    );

    // One tracker per set, addressed by decoded indices.
    for (genvar i = 0; i < NUM_SETS; i++) begin : g_set
        logic fail_hit_i, acc_hit_i, issue_hit_i, grant_i;
        assign fail_hit_i  = fail_en && (fail_set == SET_W'(i));
        assign acc_hit_i   = acc_en && (acc_set == SET_W'(i));
        assign issue_hit_i = issue && (q_head == SET_W'(i));
        assign grant_i     = enq && (cand_set == SET_W'(i));

        brs_set_tracker #(.FAIL_LIMIT(FAIL_LIMIT)) u_trk (
            .clk       (clk),
            .rst_n     (rst_n),
            .fail_hit  (fail_hit_i),
            .acc_hit   (acc_hit_i),
            .issue_hit (issue_hit_i),
            .grant     (grant_i),
            .trig      (trig_v[i]),
            .retry     (retry_v[i]),
            .in_q      (inq_v[i]),
            .pend      (pend_v[i])
        );
    end

    // Held rebuild request; raised on issue, dropped on done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            set_q <= '0;
        end else if (issue) begin
            req_q <= 1'b1;
            set_q <= q_head;
        end else if (rb_done) begin
            req_q <= 1'b0;
        end
    end

    assign rb_req = req_q;
    assign rb_set = set_q;
endmodule

// File: rtl/brs_checker.sv
// Temporal checks for the rebuild scheduler, bound to the top module.
// Assumes: the bind below connects the top's internal queue and tracker state.
module brs_checker #(
    parameter int NUM_SETS    = 16,
    parameter int QUEUE_DEPTH = 4,
    parameter int SET_W       = 4,
    parameter int QCW         = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                enable,
    input logic                acc_valid,
    input logic                rb_done,
    input logic                rb_req,
    input logic [SET_W-1:0]    rb_set,
    input logic [QCW-1:0]      q_count,
    input logic [NUM_SETS-1:0] inq_v,
    input logic [NUM_SETS-1:0] pend_v
);
    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && !rb_done) |=> (rb_req && $stable(rb_set))); // R5
    AST_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rb_req && rb_done) |=> !rb_req); // R5
    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !$rose(rb_req)); // R8
    AST_ISSUE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_req) |-> $past(acc_valid)); // R3
    AST_QUEUE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= QCW'(QUEUE_DEPTH)); // R6
    AST_PEND_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (inq_v & pend_v) == '0); // R6
endmodule

bind bloom_rebuild_sched brs_checker #(
    .NUM_SETS    (NUM_SETS),
    .QUEUE_DEPTH (QUEUE_DEPTH),
    .SET_W       (SET_W),
    .QCW         (QCW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .acc_valid (acc_valid),
    .rb_done   (rb_done),
    .rb_req    (rb_req),
    .rb_set    (rb_set),
    .q_count   (q_count),
    .inq_v     (inq_v),
    .pend_v    (pend_v)
);

// File: tb/bloom_rebuild_sched_bench.sv
`timescale 1ns/1ps
module bloom_rebuild_sched_bench;
    localparam int NS = 4, K = 2, N = 3, QD = 2, SW = 2;

    logic clk = 1'b0, rst_n = 1'b0, enable = 1'b1;
    logic fail_valid = 1'b0, acc_valid = 1'b0, rb_done = 1'b0;
    logic [SW-1:0] fail_set = '0, acc_set = '0;
    logic rb_req;
    logic [SW-1:0] rb_set;
    int n_chk = 0, n_err = 0;

    always #2.5 clk = ~clk;

    bloom_rebuild_sched #(.NUM_SETS(NS), .FAIL_LIMIT(K), .PERIOD(N),
                          .QUEUE_DEPTH(QD), .SET_W(SW)) u_bloom_rebuild_sched (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .fail_valid(fail_valid), .fail_set(fail_set),
        .acc_valid(acc_valid), .acc_set(acc_set),
        .rb_done(rb_done), .rb_req(rb_req), .rb_set(rb_set));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle of stimulus, applied at a falling edge.
    task automatic step(input bit fv, input int fs, input bit av, input int as, input bit dn);
        fail_valid = fv; fail_set = SW'(fs);
        acc_valid = av; acc_set = SW'(as); rb_done = dn;
        @(negedge clk);
        fail_valid = 1'b0; acc_valid = 1'b0; rb_done = 1'b0;
    endtask

    task automatic fail(input int s);            step(1, s, 0, 0, 0); endtask
    task automatic acc(input int s);             step(0, 0, 1, s, 0); endtask
    task automatic done();                       step(0, 0, 0, 0, 1); endtask
    task automatic accn(input int s, input int n);
        for (int j = 0; j < n; j++) acc(s);
    endtask
    task automatic want_req(input string tag, input int s);
        chk({tag, " rb_req"}, int'(rb_req), 1);
        chk({tag, " rb_set"}, int'(rb_set), s);
    endtask
    task automatic want_idle(input string tag);
        chk({tag, " rb_req"}, int'(rb_req), 0);
    endtask
    task automatic do_reset();
        rst_n = 1'b0; enable = 1'b1;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        do_reset();
        want_idle("R1 reset");
        accn(0, N);
        want_idle("R1 empty queue after reset");

        // R2/R4 sweep over every set: one short of the limit, then at the limit.
        for (int s = 0; s < NS; s++) begin
            do_reset();
            for (int f = 0; f < K - 1; f++) fail(s);
            accn((s + 1) % NS, N);
            want_idle("R2 below limit");
            fail(s);
            accn((s + 1) % NS, N - 1);
            want_idle("R3 before period ends");
            acc((s + 1) % NS);
            want_req("R2 R4 limit reached", s);
            done();
            want_idle("R5 drop after done");
        end

        // R4/R5: ordering, hold while busy, lost opportunity.
        do_reset();
        fail(1); fail(1); fail(2); fail(2);
        accn(0, N);
        want_req("R4 first", 1);
        accn(0, N);
        want_req("R5 held while busy", 1);
        done();
        want_idle("R5 after done");
        accn(0, N);
        want_req("R4 second", 2);
        done();

        // R7: fresh failures needed after issue; no duplicate entry.
        do_reset();
        for (int f = 0; f < K + 3; f++) fail(0);
        accn(1, N);
        want_req("R7 queued once", 0);
        done();
        accn(1, N);
        want_idle("R7 no duplicate entry");
        fail(0);
        accn(1, N);
        want_idle("R7 count cleared on issue");
        fail(0);
        accn(1, N);
        want_req("R7 requeued", 0);
        done();

        // R6: full queue gives pending, retried on next access.
        do_reset();
        fail(0); fail(0); fail(1); fail(1);
        fail(2); fail(2);
        acc(2); acc(3); acc(3);
        want_req("R6 head while 2 pending", 0);
        acc(2);
        done();
        acc(3); acc(3);
        want_req("R6 second", 1);
        done();
        accn(3, N);
        want_req("R6 retried set issued", 2);
        done();

        // R9: full queue, enqueue and pop together.
        do_reset();
        fail(0); fail(0); fail(1); fail(1); fail(2);
        acc(3); acc(3);
        step(1, 2, 1, 3, 0);
        want_req("R9 pop", 0);
        done();
        accn(3, N);
        want_req("R9 order", 1);
        done();
        accn(3, N);
        want_req("R9 enqueue accepted", 2);
        done();

        // R10: failure crossing beats pending retry.
        do_reset();
        fail(0); fail(0); fail(1); fail(1);
        fail(2); fail(2); fail(3);
        acc(3); acc(3);
        step(1, 3, 1, 2, 0);
        want_req("R10 pop", 0);
        done();
        accn(0, N);
        want_req("R10 next", 1);
        done();
        accn(0, N);
        want_req("R10 crossing won", 3);
        done();
        accn(0, N);
        want_idle("R10 loser still pending");
        acc(2); acc(0); acc(0);
        want_req("R10 loser retried", 2);
        done();

        // R8: enable low ignores failures, accesses and issue.
        do_reset();
        enable = 1'b0;
        fail(0); fail(0);
        enable = 1'b1;
        accn(1, N);
        want_idle("R8 failures ignored");
        fail(0);
        accn(1, N);
        want_idle("R8 count not advanced");
        fail(0);
        enable = 1'b0;
        accn(1, N);
        want_idle("R8 no issue while off");
        enable = 1'b1;
        accn(1, N - 1);
        want_idle("R8 period frozen while off");
        acc(1);
        want_req("R8 issue after re-enable", 0);
        done();

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule